// File: doc/BRIEF.md
# Bidirectional Port Source Selector

This block controls the port side of a pair of FIFOs that carry data in opposite directions between two 18-bit buses, A and B. Each port has its own direction logic. An enable request decides whether the port is driven. A source request picks what drives the port: live data taken straight from the opposite bus, or the head word of the FIFO that buffers traffic toward this port. Port B is fed live from bus A or stored from the A-to-B FIFO. Port A is fed live from bus B or stored from the B-to-A FIFO. Each port can be off, live or stored, and the two ports are set independently of each other.

The enable and source requests are sampled on the clock into a registered, one-hot path state. The data multiplexer is an AND-OR gate structure controlled by that state, so exactly one source path is open at any instant and a port never shows a word built from parts of two sources. The drive value and the drive enable come out as separate signals, so that tri-state resolution happens only in the pad wrapper above this block. When both ports are enabled in live mode at the same time, the two buses would feed each other, and a contention output reports this.

Top module: `bidir_port_mux`

## Requirements
- R1: While `rst` is high at a rising clock edge, both drive enables become 0, both drive values become 0, `contention` becomes 0, and both ports return to the live source.
- R2: `b_drv_en` equals the value `b_oe` had at the previous rising edge, and `a_drv_en` equals the value `a_oe` had at the previous rising edge.
- R3: When port B is enabled and `b_src_stored` was 0 at the previous rising edge, `b_drv` equals the current `a_bus_in`. The data passes through without a register, so a data change shows up without waiting for a clock edge.
- R4: When port B is enabled and `b_src_stored` was 1 at the previous rising edge, `b_drv` equals the current `fifo_a_q`.
- R5: When port A is enabled and `a_src_stored` was 0 at the previous rising edge, `a_drv` equals the current `b_bus_in`.
- R6: When port A is enabled and `a_src_stored` was 1 at the previous rising edge, `a_drv` equals the current `fifo_b_q`.
- R7: While a port's drive enable is 0, its drive value is all zeros, and changes on the data inputs have no effect on it.
- R8: A change on a source request takes effect at the next rising edge and not before. At every instant an enabled port shows either the whole live word or the whole stored word, never a mix of the two.
- R9: `contention` is 1 exactly when both ports are enabled and both use the live source, as set by the requests at the previous rising edge.
- R10: The enable and source settings of one port have no effect on the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_oe | input | 1 | Drive request for port A |
| b_oe | input | 1 | Drive request for port B |
| a_src_stored | input | 1 | Port A source: 0 selects live bus B, 1 selects the B-to-A FIFO |
| b_src_stored | input | 1 | Port B source: 0 selects live bus A, 1 selects the A-to-B FIFO |
| a_bus_in | input | DW (18) | Value received on bus A |
| b_bus_in | input | DW (18) | Value received on bus B |
| fifo_a_q | input | DW (18) | Head word of the A-to-B FIFO |
| fifo_b_q | input | DW (18) | Head word of the B-to-A FIFO |
| a_drv | output | DW (18) | Value to drive onto bus A |
| a_drv_en | output | 1 | Drive enable for bus A |
| b_drv | output | DW (18) | Value to drive onto bus B |
| b_drv_en | output | 1 | Drive enable for bus B |
| contention | output | 1 | Both ports are enabled in live mode |

## Verification
The bench builds the block with the default width of 18. At this width a data value can be given a different upper-bit tag for each of the four sources, so a wrong routing or a partial mix of two sources shows up as a tag mismatch. The table covers every combination of enable and source for both ports, including the one live-live case that raises contention. Directed tests then probe the instants just before and just after a source change, data changes made without a clock edge, and a reset applied during traffic.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // One-hot path code: bit 0 = live path, bit 1 = stored path.
    typedef enum logic [1:0] {
        PATH_LIVE   = 2'b01,
        PATH_STORED = 2'b10
    } path_e;

    typedef struct packed {
        logic  en;
        path_e path;
    } dir_state_t;

    localparam int NUM_DIR = 2;
    localparam int DIR_TO_A = 0;
    localparam int DIR_TO_B = 1;

    localparam dir_state_t DIR_IDLE = '{en: 1'b0, path: PATH_LIVE};

    function automatic path_e path_of(input logic stored_req);
        return stored_req ? PATH_STORED : PATH_LIVE;
    endfunction

    function automatic logic is_live(input dir_state_t s);
        return s.en && (s.path == PATH_LIVE);
    endfunction

endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
    import xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       oe_req,
    input  logic       stored_req,
    output dir_state_t st
);

    dir_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= DIR_IDLE;
        end else begin
            st_q.en   <= oe_req;
            st_q.path <= path_of(stored_req);
        end
    end

    assign st = st_q;

    // R2
    en_follow_chk: assert property (@(posedge clk) disable iff (rst)
        oe_req |=> st.en);

    // R8
    path_follow_chk: assert property (@(posedge clk) disable iff (rst)
        stored_req |=> (st.path == PATH_STORED));

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
    import xcvr_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  dir_state_t    st,
    input  logic [DW-1:0] live,
    input  logic [DW-1:0] stored,
    output logic [DW-1:0] drv,
    output logic          drv_en
);

    logic [DW-1:0] gate_live;
    logic [DW-1:0] gate_stored;

    // AND-OR structure: each path is gated by its own one-hot bit.
    always_comb begin
        gate_live   = live   & {DW{st.path[0]}};
        gate_stored = stored & {DW{st.path[1]}};
        drv         = st.en ? (gate_live | gate_stored) : '0;
        drv_en      = st.en;
    end

    // R7
    off_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> (drv == '0));

    // R8
    whole_word_chk: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> ((drv == live) || (drv == stored)));

endmodule

// File: rtl/xcvr_contention.sv
module xcvr_contention
    import xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dir_state_t st_to_a,
    input  dir_state_t st_to_b,
    input  logic       a_en_req,
    input  logic       b_en_req,
    output logic       contention
);

    assign contention = is_live(st_to_a) && is_live(st_to_b);

    // R9
    contention_en_chk: assert property (@(posedge clk) disable iff (rst)
        contention |-> ($past(a_en_req) && $past(b_en_req)));

endmodule

// File: rtl/bidir_port_mux.sv
module bidir_port_mux
    import xcvr_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_oe,
    input  logic          b_oe,
    input  logic          a_src_stored,
    input  logic          b_src_stored,
    input  logic [DW-1:0] a_bus_in,
    input  logic [DW-1:0] b_bus_in,
    input  logic [DW-1:0] fifo_a_q,
    input  logic [DW-1:0] fifo_b_q,
    output logic [DW-1:0] a_drv,
    output logic          a_drv_en,
    output logic [DW-1:0] b_drv,
    output logic          b_drv_en,
    output logic          contention
);

    logic          oe_v     [NUM_DIR];
    logic          sel_v    [NUM_DIR];
    logic [DW-1:0] live_v   [NUM_DIR];
    logic [DW-1:0] stored_v [NUM_DIR];
    logic [DW-1:0] drv_v    [NUM_DIR];
    logic          en_v     [NUM_DIR];
    dir_state_t    st_v     [NUM_DIR];

    // Direction toward port A: live from bus B, stored from the B-to-A FIFO.
    assign oe_v[DIR_TO_A]     = a_oe;
    assign sel_v[DIR_TO_A]    = a_src_stored;
    assign live_v[DIR_TO_A]   = b_bus_in;
    assign stored_v[DIR_TO_A] = fifo_b_q;
    // Direction toward port B: live from bus A, stored from the A-to-B FIFO.
    assign oe_v[DIR_TO_B]     = b_oe;
    assign sel_v[DIR_TO_B]    = b_src_stored;
    assign live_v[DIR_TO_B]   = a_bus_in;
    assign stored_v[DIR_TO_B] = fifo_a_q;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        xcvr_dir_ctrl u_ctrl (
            .clk        (clk),
            .rst        (rst),
            .oe_req     (oe_v[d]),
            .stored_req (sel_v[d]),
            .st         (st_v[d])
        );

        xcvr_path_mux #(.DW(DW)) u_mux (
            .clk    (clk),
            .rst    (rst),
            .st     (st_v[d]),
            .live   (live_v[d]),
            .stored (stored_v[d]),
            .drv    (drv_v[d]),
            .drv_en (en_v[d])
        );
    end

    xcvr_contention u_cont (
        .clk        (clk),
        .rst        (rst),
        .st_to_a    (st_v[DIR_TO_A]),
        .st_to_b    (st_v[DIR_TO_B]),
        .a_en_req   (a_oe),
        .b_en_req   (b_oe),
        .contention (contention)
    );

    assign a_drv    = drv_v[DIR_TO_A];
    assign a_drv_en = en_v[DIR_TO_A];
    assign b_drv    = drv_v[DIR_TO_B];
    assign b_drv_en = en_v[DIR_TO_B];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!a_drv_en && !b_drv_en && !contention));

    // R10
    b_indep_chk: assert property (@(posedge clk) disable iff (rst)
        b_oe |=> b_drv_en);

endmodule

// File: tb/sim_bidir_port_mux.sv
module sim_bidir_port_mux;

    localparam int DW = 18;
    localparam int NV = 10;
    // Row: {a_oe, b_oe, a_sel, b_sel, expA[1:0], expB[1:0], cont}
    // exp code: 0 = off, 1 = live, 2 = stored
    localparam logic [8:0] VEC [NV] = '{
        9'b0000_00_00_0,
        9'b1000_01_00_0,
        9'b1010_10_00_0,
        9'b0100_00_01_0,
        9'b0101_00_10_0,
        9'b1100_01_01_1,
        9'b1110_10_01_0,
        9'b1101_01_10_0,
        9'b1111_10_10_0,
        9'b0011_00_00_0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_oe = 0, b_oe = 0, a_sel = 0, b_sel = 0;
    logic [DW-1:0] a_in = '0, b_in = '0, fa = '0, fb = '0;
    logic [DW-1:0] a_drv, b_drv;
    logic a_en, b_en, cont;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bidir_port_mux #(.DW(DW)) u0 (
        .clk(clk), .rst(rst),
        .a_oe(a_oe), .b_oe(b_oe),
        .a_src_stored(a_sel), .b_src_stored(b_sel),
        .a_bus_in(a_in), .b_bus_in(b_in),
        .fifo_a_q(fa), .fifo_b_q(fb),
        .a_drv(a_drv), .a_drv_en(a_en),
        .b_drv(b_drv), .b_drv_en(b_en),
        .contention(cont)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pick(input logic [1:0] code,
                                           input logic [DW-1:0] live,
                                           input logic [DW-1:0] stored);
        return (code == 2'd0) ? '0 : (code == 2'd1) ? live : stored;
    endfunction

    task automatic set_data(input int i);
        a_in = 18'h10000 | DW'(i * 3 + 1);
        b_in = 18'h20000 | DW'(i * 5 + 2);
        fa   = 18'h04000 | DW'(i * 7 + 3);
        fb   = 18'h08000 | DW'(i * 9 + 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 a_en", DW'(a_en), '0);
        check("R1 b_en", DW'(b_en), '0);
        check("R1 a_drv", a_drv, '0);
        check("R1 b_drv", b_drv, '0);
        check("R1 cont", DW'(cont), '0);
        @(negedge clk);
        rst = 0;

        // Table walk: R2, R3, R4, R5, R6, R7, R9, R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {a_oe, b_oe, a_sel, b_sel} = VEC[i][8:5];
            set_data(i);
            @(posedge clk);
            #1;
            check("R2 a_en", DW'(a_en), DW'(VEC[i][4:3] != 2'd0));
            check("R2 b_en", DW'(b_en), DW'(VEC[i][2:1] != 2'd0));
            check("R5/R6/R7/R10 a_drv", a_drv, pick(VEC[i][4:3], b_in, fb));
            check("R3/R4/R7/R10 b_drv", b_drv, pick(VEC[i][2:1], a_in, fa));
            check("R9 cont", DW'(cont), DW'(VEC[i][0]));
        end

        // R3: data passes through without a clock edge
        @(negedge clk);
        {a_oe, b_oe, a_sel, b_sel} = 4'b0100;
        set_data(20);
        @(posedge clk);
        #1;
        a_in = 18'h15a5a;
        #1;
        check("R3 live passthrough", b_drv, 18'h15a5a);

        // R8: source change waits for the edge, whole words only
        @(negedge clk);
        b_sel = 1;
        #1;
        check("R8 before edge", b_drv, a_in);
        @(posedge clk);
        #1;
        check("R8 after edge", b_drv, fa);
        @(negedge clk);
        b_sel = 0;
        #2;
        check("R8 held stored", b_drv, fa);
        @(posedge clk);
        #1;
        check("R8 back to live", b_drv, a_in);

        // R7: disabled port ignores data changes
        @(negedge clk);
        {a_oe, b_oe} = 2'b00;
        @(posedge clk);
        #1;
        a_in = 18'h3ffff; b_in = 18'h3ffff; fa = 18'h3ffff; fb = 18'h3ffff;
        #1;
        check("R7 a_drv off", a_drv, '0);
        check("R7 b_drv off", b_drv, '0);

        // R1: reset during traffic
        @(negedge clk);
        {a_oe, b_oe, a_sel, b_sel} = 4'b1100;
        @(posedge clk);
        #1;
        check("R9 live-live", DW'(cont), DW'(1));
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1;
        check("R1 mid a_en", DW'(a_en), '0);
        check("R1 mid b_drv", b_drv, '0);
        check("R1 mid cont", DW'(cont), '0);
        @(negedge clk);
        rst = 0;
        {a_oe, b_oe, a_sel, b_sel} = 4'b0100;
        @(posedge clk);
        #1;
        check("R1 live after reset", b_drv, a_in);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule